// File: doc/BRIEF.md
# Vector Clock Persist Scheduler

This block lives inside one memory controller, just ahead of the persistent memory port. Stores arrive carrying the vector timestamp of the core that issued them together with that core's index. They wait in a small pending pool. The scheduler keeps its own vector clock and releases a store to memory only when the store's timestamp is the next step in causal order with respect to that clock. Each released store is then folded into the local clock.

A controller sees only part of the system's store traffic, so its clock can fall behind the true causal frontier. Peer controllers therefore exchange clocks. The block emits a strobe every programmable number of cycles, and its current clock is always visible on a dedicated output. When a peer's clock arrives, it is merged in by taking the larger value at each element. This merge can make a stalled store eligible.

Top module: `vc_persist_sched`

## Requirements
- R1: A pending store from core i is eligible only if, for every element j other than i, element j of its timestamp is less than or equal to element j of the local clock.
- R2: Element i of an eligible store's timestamp must equal the local clock's element i plus one (modulo the element width). A store that fails R1 or R2 stays pending and is not output.
- R3: When a store issues, the local clock becomes the element-wise maximum of the clock and that store's timestamp. Clock elements never decrease.
- R4: With period P = `bc_period` greater than 0, `bc_valid` pulses for one cycle once every P cycles. When P is 0, no pulse occurs. `bc_clock` always shows the local clock.
- R5: When `peer_valid` is high, the local clock is replaced at the next edge by its element-wise maximum with `peer_clock`. Stores that this unblocks then issue.
- R6: At most one store issues per cycle. If several pending stores are eligible, the one in the lowest pool entry issues first. An accepted store takes the lowest free entry.
- R7: The pool holds 8 entries. `in_ready` is low exactly when all 8 entries are occupied. While `in_ready` is low, `in_valid` is ignored and no store is recorded.
- R8: If a peer clock arrives in the same cycle that a store issues, the clock becomes the element-wise maximum of the old clock, the store's timestamp and the peer clock, all applied in one update.
- R9: After reset the clock is all zeros, the pool is empty, `in_ready` is high, and `out_valid` and `bc_valid` are low.
- R10: Suppose a store is accepted on clock edge k and is eligible against the clock held after edge k. It then appears on the output port with `out_valid` high for one cycle after edge k+1, and its core, timestamp, address and data are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming store valid |
| in_ready | output | 1 | Pool can accept a store |
| in_core | input | $clog2(NCORES) | Issuing core index |
| in_ts | input | NCORES*TSW | Store timestamp, element j at bits [j*TSW +: TSW] |
| in_addr | input | ADDRW | Store address |
| in_data | input | DATAW | Store data |
| peer_valid | input | 1 | Peer clock broadcast present |
| peer_clock | input | NCORES*TSW | Peer controller's clock |
| bc_period | input | PERW | Broadcast period in cycles, 0 disables |
| out_valid | output | 1 | A store is persisted this cycle |
| out_core | output | $clog2(NCORES) | Core of persisted store |
| out_ts | output | NCORES*TSW | Timestamp of persisted store |
| out_addr | output | ADDRW | Address of persisted store |
| out_data | output | DATAW | Data of persisted store |
| bc_valid | output | 1 | Broadcast strobe |
| bc_clock | output | NCORES*TSW | Local vector clock |

## Verification
Two clock updates can fall in the same cycle: the merge that follows a store's release, and the merge of an incoming peer broadcast. The bench provokes this by accepting an eligible store and then asserting `peer_valid` in the cycle in which that store leaves the pool. It uses several peer vectors, some larger than the store's timestamp at some elements and smaller at others. The result is judged by comparing `bc_clock` one edge later against the three-way element-wise maximum, which the bench computes itself. It also checks that the store still appears on the output in that cycle.

// File: rtl/vcps_pkg.sv
package vcps_pkg;
    localparam int unsigned VC_CORES = 4;
    localparam int unsigned VC_TSW   = 8;
    localparam int unsigned VC_ADDRW = 16;
    localparam int unsigned VC_DATAW = 32;
    localparam int unsigned VC_DEPTH = 8;
    localparam int unsigned VC_PERW  = 12;
endpackage

// File: rtl/vc_elig_check.sv
module vc_elig_check #(
    parameter int unsigned NCORES = 4,
    parameter int unsigned TSW    = 8,
    parameter int unsigned CIW    = 2
) (
    input  logic                  valid,
    input  logic [CIW-1:0]        core,
    input  logic [NCORES*TSW-1:0] ts,
    input  logic [NCORES*TSW-1:0] clk_vec,
    output logic                  elig
);
    logic [TSW-1:0] te, ce;
    always_comb begin
        elig = valid;
        te   = '0;
        ce   = '0;
        for (int c = 0; c < int'(NCORES); c++) begin
            te = ts[c*TSW +: TSW];
            ce = clk_vec[c*TSW +: TSW];
            if (core == CIW'(c)) begin
                if (te != ce + TSW'(1)) elig = 1'b0;
            end else if (te > ce) begin
                elig = 1'b0;
            end
        end
    end
endmodule

// File: rtl/vc_first_pick.sv
module vc_first_pick #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = 3
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  onehot,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        onehot = req & (~req + N'(1));
        any    = |req;
        idx    = '0;
        for (int k = int'(N) - 1; k >= 0; k--) begin
            if (req[k]) idx = IW'(k);
        end
    end
endmodule

// File: rtl/vc_merge.sv
module vc_merge #(
    parameter int unsigned NCORES = 4,
    parameter int unsigned TSW    = 8
) (
    input  logic [NCORES*TSW-1:0] a,
    input  logic [NCORES*TSW-1:0] b,
    input  logic                  use_b,
    output logic [NCORES*TSW-1:0] m
);
    for (genvar c = 0; c < NCORES; c++) begin : g_el
        assign m[c*TSW +: TSW] = (use_b && (b[c*TSW +: TSW] > a[c*TSW +: TSW]))
                               ? b[c*TSW +: TSW] : a[c*TSW +: TSW];
    end
endmodule

// File: rtl/vc_persist_sched.sv
module vc_persist_sched
    import vcps_pkg::*;
#(
    parameter int unsigned NCORES = VC_CORES,
    parameter int unsigned TSW    = VC_TSW,
    parameter int unsigned ADDRW  = VC_ADDRW,
    parameter int unsigned DATAW  = VC_DATAW,
    parameter int unsigned DEPTH  = VC_DEPTH,
    parameter int unsigned PERW   = VC_PERW
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [$clog2(NCORES)-1:0]   in_core,
    input  logic [NCORES*TSW-1:0]       in_ts,
    input  logic [ADDRW-1:0]            in_addr,
    input  logic [DATAW-1:0]            in_data,
    input  logic                        peer_valid,
    input  logic [NCORES*TSW-1:0]       peer_clock,
    input  logic [PERW-1:0]             bc_period,
    output logic                        out_valid,
    output logic [$clog2(NCORES)-1:0]   out_core,
    output logic [NCORES*TSW-1:0]       out_ts,
    output logic [ADDRW-1:0]            out_addr,
    output logic [DATAW-1:0]            out_data,
    output logic                        bc_valid,
    output logic [NCORES*TSW-1:0]       bc_clock
);
    localparam int unsigned CIW = $clog2(NCORES);
    localparam int unsigned PIW = $clog2(DEPTH);
    localparam int unsigned VW  = NCORES * TSW;

    typedef struct packed {
        logic [DEPTH-1:0]            vld;
        logic [DEPTH-1:0][CIW-1:0]   core;
        logic [DEPTH-1:0][VW-1:0]    ts;
        logic [DEPTH-1:0][ADDRW-1:0] addr;
        logic [DEPTH-1:0][DATAW-1:0] data;
        logic [VW-1:0]               clock;
        logic [PERW-1:0]             tcnt;
        logic                        bc;
        logic                        ov;
        logic [CIW-1:0]              ocore;
        logic [VW-1:0]               ots;
        logic [ADDRW-1:0]            oaddr;
        logic [DATAW-1:0]            odata;
    } sched_st_t;

    sched_st_t st_d, st_q;

    logic [DEPTH-1:0] elig, grant;
    logic [PIW-1:0]   gidx, fidx;
    logic             g_any, f_any;
    logic [DEPTH-1:0] freemask;
    logic [VW-1:0]    issue_ts, m_commit, m_all;
    logic [PERW:0]    tnext;

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        vc_elig_check #(.NCORES(NCORES), .TSW(TSW), .CIW(CIW)) i_elig (
            .valid   (st_q.vld[e]),
            .core    (st_q.core[e]),
            .ts      (st_q.ts[e]),
            .clk_vec (st_q.clock),
            .elig    (elig[e])
        );
    end

    vc_first_pick #(.N(DEPTH), .IW(PIW)) i_grant (
        .req(elig), .onehot(grant), .idx(gidx), .any(g_any)
    );

    assign freemask = ~st_q.vld;
    logic [DEPTH-1:0] free_oh;
    vc_first_pick #(.N(DEPTH), .IW(PIW)) i_free (
        .req(freemask), .onehot(free_oh), .idx(fidx), .any(f_any)
    );

    assign issue_ts = st_q.ts[gidx];

    vc_merge #(.NCORES(NCORES), .TSW(TSW)) i_mcommit (
        .a(st_q.clock), .b(issue_ts), .use_b(g_any), .m(m_commit)
    );
    vc_merge #(.NCORES(NCORES), .TSW(TSW)) i_mpeer (
        .a(m_commit), .b(peer_clock), .use_b(peer_valid), .m(m_all)
    );

    assign in_ready = f_any;

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        st_d.bc = 1'b0;
        tnext   = {1'b0, st_q.tcnt} + (PERW+1)'(1);
        if (g_any) begin
            st_d.vld[gidx] = 1'b0;
            st_d.ov        = 1'b1;
            st_d.ocore     = st_q.core[gidx];
            st_d.ots       = issue_ts;
            st_d.oaddr     = st_q.addr[gidx];
            st_d.odata     = st_q.data[gidx];
        end
        if (in_valid && f_any) begin
            st_d.vld[fidx]  = 1'b1;
            st_d.core[fidx] = in_core;
            st_d.ts[fidx]   = in_ts;
            st_d.addr[fidx] = in_addr;
            st_d.data[fidx] = in_data;
        end
        st_d.clock = m_all;
        if (bc_period == '0) begin
            st_d.tcnt = '0;
        end else if (tnext >= {1'b0, bc_period}) begin
            st_d.tcnt = '0;
            st_d.bc   = 1'b1;
        end else begin
            st_d.tcnt = tnext[PERW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ov;
    assign out_core  = st_q.ocore;
    assign out_ts    = st_q.ots;
    assign out_addr  = st_q.oaddr;
    assign out_data  = st_q.odata;
    assign bc_valid  = st_q.bc;
    assign bc_clock  = st_q.clock;

    // ---------------- assertions ----------------
    logic [VW-1:0] clk_prev_q;
    always_ff @(posedge clk) clk_prev_q <= st_q.clock;

    logic issue_ok;
    always_comb begin
        issue_ok = 1'b1;
        for (int c = 0; c < int'(NCORES); c++) begin
            if (out_core == CIW'(c)) begin
                if (out_ts[c*TSW +: TSW] != clk_prev_q[c*TSW +: TSW] + TSW'(1)) issue_ok = 1'b0;
            end else if (out_ts[c*TSW +: TSW] > clk_prev_q[c*TSW +: TSW]) begin
                issue_ok = 1'b0;
            end
        end
    end

    // R1 R2
    issue_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ov |-> issue_ok);

    for (genvar c = 0; c < NCORES; c++) begin : g_chk
        // R3
        clock_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(!rst_n) |-> st_q.clock[c*TSW +: TSW] >= $past(st_q.clock[c*TSW +: TSW]));
        // R3
        commit_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.ov |-> st_q.clock[c*TSW +: TSW] >= st_q.ots[c*TSW +: TSW]);
        // R5
        peer_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            peer_valid |=> st_q.clock[c*TSW +: TSW] >= $past(peer_clock[c*TSW +: TSW]));
    end

    // R6
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> $countones(st_q.vld) <= $past($countones(st_q.vld)));

    // R4
    bc_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && !$past(!rst_n)) |-> $past(bc_period) != '0);
endmodule

// File: tb/test_vc_persist_sched.sv
module test_vc_persist_sched;
    localparam int NC = 4;
    localparam int TW = 8;
    localparam int VW = NC * TW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [1:0] in_core = '0;
    logic [VW-1:0] in_ts = '0;
    logic [15:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic peer_valid = 1'b0;
    logic [VW-1:0] peer_clock = '0;
    logic [11:0] bc_period = '0;
    logic out_valid;
    logic [1:0] out_core;
    logic [VW-1:0] out_ts;
    logic [15:0] out_addr;
    logic [31:0] out_data;
    logic bc_valid;
    logic [VW-1:0] bc_clock;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    vc_persist_sched i_vc_persist_sched (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_core(in_core), .in_ts(in_ts), .in_addr(in_addr), .in_data(in_data),
        .peer_valid(peer_valid), .peer_clock(peer_clock), .bc_period(bc_period),
        .out_valid(out_valid), .out_core(out_core), .out_ts(out_ts),
        .out_addr(out_addr), .out_data(out_data), .bc_valid(bc_valid),
        .bc_clock(bc_clock)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] vmax(input logic [VW-1:0] a, input logic [VW-1:0] b);
        logic [VW-1:0] r;
        for (int c = 0; c < NC; c++)
            r[c*TW +: TW] = (a[c*TW +: TW] > b[c*TW +: TW]) ? a[c*TW +: TW] : b[c*TW +: TW];
        return r;
    endfunction

    function automatic logic [VW-1:0] mk(input int e0, input int e1, input int e2, input int e3);
        return {TW'(e3), TW'(e2), TW'(e1), TW'(e0)};
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; peer_valid = 1'b0; bc_period = '0;
        step(); step();
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int strobes;
        logic [VW-1:0] pv;
        logic [VW-1:0] ts;
        bit exp_el;

        // R9 reset state
        do_reset();
        check(in_ready == 1'b1, "R9 in_ready", 64'(in_ready), 1);
        check(out_valid == 1'b0, "R9 out_valid", 64'(out_valid), 0);
        check(bc_valid == 1'b0, "R9 bc_valid", 64'(bc_valid), 0);
        check(bc_clock == '0, "R9 clock", 64'(bc_clock), 0);

        // R1 R2 R3 R10 sweep: clock preset to all ones, ts elements 0..2
        for (int core = 0; core < NC; core++) begin
            for (int k = 0; k < 81; k++) begin
                do_reset();
                ts = mk(k % 3, (k / 3) % 3, (k / 9) % 3, (k / 27) % 3);
                exp_el = 1'b1;
                for (int c = 0; c < NC; c++) begin
                    if (c == core) begin
                        if (ts[c*TW +: TW] != 2) exp_el = 1'b0;
                    end else if (ts[c*TW +: TW] > 1) exp_el = 1'b0;
                end
                peer_valid = 1'b1; peer_clock = mk(1, 1, 1, 1);
                step();
                peer_valid = 1'b0;
                in_valid = 1'b1; in_core = 2'(core); in_ts = ts;
                in_addr = 16'(k); in_data = 32'(core * 1000 + k);
                step();
                in_valid = 1'b0;
                step();
                check(out_valid == exp_el, "R1 R2 eligibility", 64'(out_valid), 64'(exp_el));
                if (exp_el) begin
                    check(out_ts == ts && out_core == 2'(core) && out_data == 32'(core * 1000 + k)
                          && out_addr == 16'(k), "R10 output fields", 64'(out_data), 64'(core * 1000 + k));
                    check(bc_clock == vmax(mk(1, 1, 1, 1), ts), "R3 merged clock",
                          64'(bc_clock), 64'(vmax(mk(1, 1, 1, 1), ts)));
                end else begin
                    step();
                    check(out_valid == 1'b0 && bc_clock == mk(1, 1, 1, 1), "R2 stalled store held",
                          64'(bc_clock), 64'(mk(1, 1, 1, 1)));
                end
            end
        end

        // R5 R6: two stores blocked, one peer merge frees both; lower entry first
        do_reset();
        in_valid = 1'b1; in_core = 2'd0; in_ts = mk(1, 0, 1, 0); in_data = 32'hA;
        step();
        in_core = 2'd1; in_ts = mk(0, 1, 1, 0); in_data = 32'hB;
        step();
        in_valid = 1'b0;
        step();
        check(out_valid == 1'b0, "R5 blocked before merge", 64'(out_valid), 0);
        peer_valid = 1'b1; peer_clock = mk(0, 0, 1, 0);
        step();
        peer_valid = 1'b0;
        check(bc_clock == mk(0, 0, 1, 0), "R5 peer merge", 64'(bc_clock), 64'(mk(0, 0, 1, 0)));
        step();
        check(out_valid && out_data == 32'hA, "R6 lowest entry first", 64'(out_data), 64'hA);
        step();
        check(out_valid && out_data == 32'hB, "R6 second next cycle", 64'(out_data), 64'hB);
        check(bc_clock == mk(1, 1, 1, 0), "R3 clock after both", 64'(bc_clock), 64'(mk(1, 1, 1, 0)));

        // R7 R6 R5: fill pool, ninth ignored, drain one per cycle in order
        do_reset();
        for (int k = 0; k < 8; k++) begin
            check(in_ready == 1'b1, "R7 ready while not full", 64'(in_ready), 1);
            in_valid = 1'b1; in_core = 2'd0; in_ts = mk(k + 1, 0, 3, 0); in_data = 32'(100 + k);
            step();
        end
        check(in_ready == 1'b0, "R7 ready low when full", 64'(in_ready), 0);
        in_ts = mk(9, 0, 3, 0); in_data = 32'd999;
        step(); step();
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R7 still full", 64'(in_ready), 0);
        peer_valid = 1'b1; peer_clock = mk(0, 0, 3, 0);
        step();
        peer_valid = 1'b0;
        for (int k = 0; k < 8; k++) begin
            step();
            check(out_valid && out_data == 32'(100 + k), "R6 drain order", 64'(out_data), 64'(100 + k));
        end
        for (int k = 0; k < 4; k++) begin
            step();
            check(out_valid == 1'b0, "R7 ignored store absent", 64'(out_data), 0);
        end
        check(bc_clock == mk(8, 0, 3, 0), "R7 final clock", 64'(bc_clock), 64'(mk(8, 0, 3, 0)));

        // R8 simultaneous peer merge and commit
        for (int v = 0; v < 3; v++) begin
            do_reset();
            pv = (v == 0) ? mk(2, 0, 5, 0) : (v == 1) ? mk(0, 4, 0, 0) : mk(3, 0, 0, 7);
            in_valid = 1'b1; in_core = 2'd1; in_ts = mk(0, 1, 0, 0); in_data = 32'(50 + v);
            step();
            in_valid = 1'b0;
            peer_valid = 1'b1; peer_clock = pv;
            step();
            peer_valid = 1'b0;
            check(out_valid && out_data == 32'(50 + v), "R8 store issued", 64'(out_data), 64'(50 + v));
            check(bc_clock == vmax(pv, mk(0, 1, 0, 0)), "R8 three-way merge",
                  64'(bc_clock), 64'(vmax(pv, mk(0, 1, 0, 0))));
        end

        // R4 broadcast period
        for (int p = 0; p < 5; p++) begin
            do_reset();
            bc_period = 12'(p);
            step(); step(); step(); step(); step(); step(); step(); step(); step(); step();
            strobes = 0;
            for (int k = 0; k < 60; k++) begin
                step();
                if (bc_valid) strobes++;
            end
            check(strobes == ((p == 0) ? 0 : 60 / p), "R4 strobe count",
                  64'(strobes), 64'((p == 0) ? 0 : 60 / p));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule